// File: doc/BRIEF.md
# Parallel-Output ADC Conversion Sequencer

This block sits on the host side of a 16-bit successive-approximation converter that has a parallel output bus. It produces the two active-low control lines: a read/convert select, where low means convert, and a chip select. It also watches the converter's ready line, which goes low for the length of a conversion and returns high when the result is on the bus. A conversion begins on a single start pulse, or repeats at a fixed rate while free-run is enabled. The sequencer enforces the edge ordering, setup time and spacing the converter needs so that the acquisition phase is never shortened.

The control lines move in a fixed order:

- The convert select goes low first and is held for a setup interval.
- The chip select then falls, and that edge starts the converter.
- A few cycles later the convert select returns high, while the chip select stays low so the bus will be driven when the conversion ends.
- Neither line moves again until the ready line rises.

The ready line passes through a two-flop synchronizer. On its synchronized rising edge the bus word is captured into a holding register, a one-cycle valid strobe is issued, and the chip select is released. Because the convert select is already high at that point, no back-to-back conversion can begin.

Sticky flags record start requests that were refused and conversions that overran a configurable time limit. Every timing value is a parameter counted in system-clock cycles.

Top module: `adc_conv_sequencer`

## Requirements
- R1: While reset is asserted and after it, with no request, `adc_rc_o` and `adc_cs_n_o` are high and `result_vld_o`, `overrun_o` and `timeout_o` are low.
- R2: On a start, `adc_rc_o` goes low exactly SETUP_CYC cycles before `adc_cs_n_o` falls. `adc_cs_n_o` never falls while `adc_rc_o` is high, and `adc_rc_o` never falls while `adc_cs_n_o` is low.
- R3: `adc_rc_o` returns high exactly LOW_CYC cycles after `adc_cs_n_o` falls, with `adc_cs_n_o` still low. Neither line changes again until the converter's ready line has risen.
- R4: Accepted starts are at least PERIOD_CYC cycles apart. With `run_en_i` held high, successive conversions start exactly PERIOD_CYC cycles apart.
- R5: The third rising clock edge after `adc_idle_i` rises loads `adc_data_i` into `result_o`. At that same edge `result_vld_o` goes high for one cycle and `adc_cs_n_o` returns high.
- R6: A `start_req_i` that arrives while a conversion is in flight, or while the spacing interval is still running, starts nothing. It sets `overrun_o`, which stays high until reset.
- R7: If the ready line has not risen TIMEOUT_CYC cycles after `adc_cs_n_o` fell, `timeout_o` is set and stays set, `adc_cs_n_o` is released without a valid strobe, and later requests are served normally.
- R8: A rise of `adc_idle_i` when no conversion is awaited produces no valid strobe and leaves `result_o` unchanged.
- R9: A single one-cycle `start_req_i` with `run_en_i` low produces exactly one conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req_i | input | 1 | One-cycle request for a single conversion |
| run_en_i | input | 1 | Free-run enable; starts a conversion whenever allowed |
| adc_idle_i | input | 1 | Converter ready line, low while converting (asynchronous) |
| adc_data_i | input | DATA_W | Converter parallel output bus |
| adc_rc_o | output | 1 | Read/convert select, low selects convert |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| result_o | output | DATA_W | Holding register with the last captured result |
| result_vld_o | output | 1 | One-cycle strobe when `result_o` is updated |
| overrun_o | output | 1 | Sticky flag: a start request was refused |
| timeout_o | output | 1 | Sticky flag: a conversion exceeded TIMEOUT_CYC |

## Verification
The bench models a converter that reacts only to a chip-select fall with the convert line low, holds its ready line low for a chosen time, and drives the bus only while it is being read. Anything else on the bus is a poison word, so a capture taken one edge too early returns the poison word instead of the expected value.

A monitor measures the setup and release intervals and the spacing between starts, and flags any reversed edge order or any control movement during the conversion.

Directed cases cover the following:
- A second request during a conversion. A design that queued it instead of refusing it would run an extra conversion and leave the overrun flag clear.
- A converter that hangs past the time limit and then raises its ready line late. A design that kept waiting would hang or capture stale data.
- Free-run pacing. An off-by-one reload of the spacing counter shows up as a period that is one cycle off.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_HOLD  = 2'd2,
    ST_WAIT  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;
  logic              last_q;

  // shift chain built stage by stage
  assign sh_d[0] = d_i;
  for (genvar g = 1; g < STAGES; g++) begin : g_chain
    assign sh_d[g] = sh_q[g-1];
  end

  // idle level is high, so reset to high to avoid a false edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      last_q <= 1'b1;
    end else begin
      sh_q   <= sh_d;
      last_q <= sh_q[STAGES-1];
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~last_q;

  assert_rise_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/adc_gap_timer.sv
module adc_gap_timer #(
  parameter int PERIOD_CYC = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic done_o
);
  localparam int CW = $clog2(PERIOD_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign done_o = (cnt_q == '0);
  assign cnt_en = load_i | ~done_o;

  always_comb begin
    if (load_i) cnt_d = CW'(PERIOD_CYC - 1);
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_gap_blocks_after_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !done_o);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SETUP_CYC   = 10,
  parameter int LOW_CYC     = 5,
  parameter int TIMEOUT_CYC = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req_i,
  input  logic              run_en_i,
  input  logic              gap_done_i,
  input  logic              busy_rise_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              accept_o,
  output logic              rc_o,
  output logic              cs_n_o,
  output logic [DATA_W-1:0] result_o,
  output logic              result_vld_o,
  output logic              overrun_o,
  output logic              timeout_o
);
  localparam int PH_MAX = (SETUP_CYC > LOW_CYC) ? SETUP_CYC : LOW_CYC;
  localparam int PW     = $clog2(PH_MAX + 1);
  localparam int TW     = $clog2(TIMEOUT_CYC + 1);

  seq_state_e        state_q, state_d;
  logic [PW-1:0]     ph_q, ph_d;
  logic [TW-1:0]     tmo_q, tmo_d;
  logic              rc_q, cs_n_q;
  logic              rc_d, cs_n_d;
  logic [DATA_W-1:0] result_q;
  logic              result_vld_q, overrun_q, timeout_q;
  logic              can_go, cap_en, tmo_hit, refuse;

  assign can_go   = (state_q == ST_IDLE) && gap_done_i;
  assign accept_o = (start_req_i | run_en_i) && can_go;
  assign refuse   = start_req_i && !can_go;
  assign tmo_hit  = (state_q == ST_WAIT) && !busy_rise_i && (tmo_q == TW'(TIMEOUT_CYC - 1));
  assign cap_en   = (state_q == ST_WAIT) && busy_rise_i;

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    tmo_d   = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept_o) begin
          state_d = ST_SETUP;
          ph_d    = PW'(SETUP_CYC - 1);
        end
      end
      ST_SETUP: begin
        if (ph_q == '0) begin
          state_d = ST_HOLD;
          ph_d    = PW'(LOW_CYC - 1);
        end else begin
          ph_d = ph_q - 1'b1;
        end
      end
      ST_HOLD: begin
        tmo_d = tmo_q + 1'b1;
        if (ph_q == '0) state_d = ST_WAIT;
        else            ph_d    = ph_q - 1'b1;
      end
      ST_WAIT: begin
        tmo_d = tmo_q + 1'b1;
        if (cap_en || tmo_hit) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    rc_d   = !((state_d == ST_SETUP) || (state_d == ST_HOLD));
    cs_n_d = !((state_d == ST_HOLD) || (state_d == ST_WAIT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      ph_q         <= '0;
      tmo_q        <= '0;
      rc_q         <= 1'b1;
      cs_n_q       <= 1'b1;
      result_vld_q <= 1'b0;
      overrun_q    <= 1'b0;
      timeout_q    <= 1'b0;
    end else begin
      state_q      <= state_d;
      ph_q         <= ph_d;
      tmo_q        <= tmo_d;
      rc_q         <= rc_d;
      cs_n_q       <= cs_n_d;
      result_vld_q <= cap_en;
      if (refuse)  overrun_q <= 1'b1;
      if (tmo_hit) timeout_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      result_q <= '0;
    else if (cap_en) result_q <= data_i;
  end

  assign rc_o         = rc_q;
  assign cs_n_o       = cs_n_q;
  assign result_o     = result_q;
  assign result_vld_o = result_vld_q;
  assign overrun_o    = overrun_q;
  assign timeout_o    = timeout_q;

  assert_cs_needs_rc_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_q) |-> (!rc_q && !$past(rc_q)));
  assert_rc_never_after_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rc_q) |-> cs_n_q);
  assert_static_in_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && $past(state_q) == ST_WAIT) |-> ($stable(rc_q) && $stable(cs_n_q)));
  assert_start_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rc_q) |-> $past(gap_done_i));
  assert_vld_from_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld_q |-> ($past(busy_rise_i) && cs_n_q));
  assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overrun_q) |-> overrun_q);
  assert_timeout_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_q) |-> (cs_n_q && !result_vld_q));
endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer #(
  parameter int DATA_W      = 16,
  parameter int SETUP_CYC   = 10,
  parameter int LOW_CYC     = 5,
  parameter int PERIOD_CYC  = 400,
  parameter int TIMEOUT_CYC = 600,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req_i,
  input  logic              run_en_i,
  input  logic              adc_idle_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              adc_rc_o,
  output logic              adc_cs_n_o,
  output logic [DATA_W-1:0] result_o,
  output logic              result_vld_o,
  output logic              overrun_o,
  output logic              timeout_o
);
  logic busy_rise;
  logic gap_done;
  logic accept;

  adc_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (adc_idle_i),
    .rise_o (busy_rise)
  );

  adc_gap_timer #(.PERIOD_CYC(PERIOD_CYC)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .done_o (gap_done)
  );

  adc_seq_fsm #(
    .DATA_W      (DATA_W),
    .SETUP_CYC   (SETUP_CYC),
    .LOW_CYC     (LOW_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req_i  (start_req_i),
    .run_en_i     (run_en_i),
    .gap_done_i   (gap_done),
    .busy_rise_i  (busy_rise),
    .data_i       (adc_data_i),
    .accept_o     (accept),
    .rc_o         (adc_rc_o),
    .cs_n_o       (adc_cs_n_o),
    .result_o     (result_o),
    .result_vld_o (result_vld_o),
    .overrun_o    (overrun_o),
    .timeout_o    (timeout_o)
  );
endmodule

// File: tb/adc_conv_sequencer_tb.sv
module adc_conv_sequencer_tb;
  localparam int DATA_W      = 16;
  localparam int SETUP_CYC   = 10;
  localparam int LOW_CYC     = 5;
  localparam int PERIOD_CYC  = 400;
  localparam int TIMEOUT_CYC = 600;
  localparam logic [15:0] POISON = 16'h5A5A;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_req, run_en;
  logic              adc_idle;
  logic [DATA_W-1:0] adc_data;
  logic              rc, cs_n;
  logic [DATA_W-1:0] result;
  logic              vld, overrun, tmo;

  int  n_chk = 0, n_err = 0;
  int  cyc = 0;
  int  n_conv = 0, n_vld = 0;
  int  conv_len = 330;
  bit  hang = 1'b0;
  bit  finished = 1'b0;

  // converter model state
  logic [15:0] data_val;
  logic        in_conv, prev_cs;
  int          left, busy_rise_cyc;

  // monitor state
  logic m_rc_p, m_cs_p;
  int   rc_fall_cyc = 0, last_cs_fall = -1;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_conv_sequencer u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req_i  (start_req),
    .run_en_i     (run_en),
    .adc_idle_i   (adc_idle),
    .adc_data_i   (adc_data),
    .adc_rc_o     (rc),
    .adc_cs_n_o   (cs_n),
    .result_o     (result),
    .result_vld_o (vld),
    .overrun_o    (overrun),
    .timeout_o    (tmo)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit bus_driven(input logic c, input logic r, input logic idle);
    return (!c && r && idle);
  endfunction

  // data bus: driven only while being read and not converting
  assign adc_data = bus_driven(cs_n, rc, adc_idle) ? data_val : POISON;

  // converter model
  always @(negedge clk) begin
    if (!rst_n) begin
      adc_idle <= 1'b1; in_conv <= 1'b0; prev_cs <= 1'b1; left <= 0;
      data_val <= 16'h0000; busy_rise_cyc <= 0;
    end else begin
      prev_cs <= cs_n;
      if (prev_cs && !cs_n && !rc && adc_idle) begin
        adc_idle <= 1'b0; in_conv <= 1'b1;
        left <= hang ? 800 : conv_len;
        n_conv <= n_conv + 1;
      end else if (in_conv) begin
        if (left == 0) begin
          adc_idle <= 1'b1; in_conv <= 1'b0;
          data_val <= 16'($urandom);
          busy_rise_cyc <= cyc;
        end else begin
          left <= left - 1;
        end
      end
    end
  end

  // timing monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      m_rc_p = 1'b1; m_cs_p = 1'b1;
    end else begin
      if (m_rc_p && !rc) rc_fall_cyc = cyc;
      if (m_cs_p && !cs_n) begin
        chk(rc == 1'b0, "R2 cs fell while rc high", rc, 0);
        chk(cyc - rc_fall_cyc == SETUP_CYC, "R2 setup", cyc - rc_fall_cyc, SETUP_CYC);
        if (last_cs_fall >= 0)
          chk(cyc - last_cs_fall >= PERIOD_CYC, "R4 spacing", cyc - last_cs_fall, PERIOD_CYC);
        last_cs_fall = cyc;
      end
      if (!m_cs_p && !cs_n && m_rc_p && !rc)
        chk(1'b0, "R2 rc fell while cs low", 0, 1);
      if (!cs_n && !m_rc_p && rc)
        chk(cyc - last_cs_fall == LOW_CYC, "R3 release", cyc - last_cs_fall, LOW_CYC);
      if (!hang && !adc_idle && rc && (!m_rc_p ? 1'b0 : 1'b1) && !m_cs_p && cs_n)
        chk(1'b0, "R3 cs moved before ready rose", 1, 0);
      if (!hang && !adc_idle && !cs_n && m_rc_p && !rc)
        chk(1'b0, "R3 rc moved before ready rose", 0, 1);
      if (vld) begin
        n_vld++;
        chk(result == data_val, "R5 data", result, data_val);
        chk(cyc - busy_rise_cyc == 3, "R5 latency", cyc - busy_rise_cyc, 3);
        chk(cs_n == 1'b1, "R5 cs released", cs_n, 1);
      end
      m_rc_p = rc; m_cs_p = cs_n;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R9 watchdog expired act=0 exp=1");
    summary();
  end

  initial begin
    int n0, v0, prev_c;
    logic [15:0] saved;
    void'($urandom(32'd2024));
    rst_n = 1'b0; start_req = 1'b0; run_en = 1'b0;
    wait_cyc(3);
    chk(rc == 1'b1 && cs_n == 1'b1, "R1 controls in reset", {rc, cs_n}, 2'b11);
    #1 rst_n = 1'b1;
    wait_cyc(3);
    chk(rc == 1'b1 && cs_n == 1'b1, "R1 controls idle", {rc, cs_n}, 2'b11);
    chk(vld == 1'b0, "R1 vld", vld, 0);
    chk(overrun == 1'b0 && tmo == 1'b0, "R1 flags", {overrun, tmo}, 0);

    // single request yields one conversion
    pulse_start();
    while (n_vld == 0) @(negedge clk);
    chk(n_conv == 1, "R9 one conversion", n_conv, 1);
    wait_cyc(600);
    chk(n_conv == 1 && rc == 1'b1, "R9 no further conversion", n_conv, 1);

    // refused request during a conversion
    n0 = n_conv;
    pulse_start();
    wait_cyc(100);
    chk(overrun == 1'b0, "R6 overrun clear before refusal", overrun, 0);
    pulse_start();
    wait_cyc(600);
    chk(n_conv == n0 + 1, "R6 refused request started nothing", n_conv, n0 + 1);
    chk(overrun == 1'b1, "R6 overrun set", overrun, 1);
    wait_cyc(300);
    chk(overrun == 1'b1, "R6 overrun sticky", overrun, 1);

    // free-run pacing
    prev_c = -1;
    @(negedge clk) run_en = 1'b1;
    for (int k = 0; k < 5; k++) begin
      n0 = n_conv;
      while (n_conv == n0) begin @(negedge clk); #1; end
      if (prev_c >= 0)
        chk(cyc - prev_c == PERIOD_CYC, "R4 free-run period", cyc - prev_c, PERIOD_CYC);
      prev_c = cyc;
    end
    @(negedge clk) run_en = 1'b0;
    wait_cyc(800);

    // random single requests with varying conversion time
    for (int i = 0; i < 20; i++) begin
      conv_len = 300 + int'($urandom % 60);
      wait_cyc(int'($urandom % 700));
      pulse_start();
    end
    wait_cyc(800);
    conv_len = 330;

    // hung conversion followed by a late ready edge
    v0 = n_vld;
    hang = 1'b1;
    pulse_start();
    wait_cyc(500);
    chk(tmo == 1'b0, "R7 no early timeout", tmo, 0);
    wait_cyc(200);
    chk(tmo == 1'b1, "R7 timeout set", tmo, 1);
    chk(cs_n == 1'b1, "R7 cs released", cs_n, 1);
    chk(n_vld == v0, "R7 no strobe on timeout", n_vld, v0);
    saved = result;
    wait_cyc(200);
    chk(n_vld == v0, "R8 late ready ignored", n_vld, v0);
    chk(result == saved, "R8 result unchanged", result, saved);
    hang = 1'b0;
    wait_cyc(50);
    pulse_start();
    wait_cyc(450);
    chk(n_vld == v0 + 1, "R7 recovery after timeout", n_vld, v0 + 1);
    chk(tmo == 1'b1, "R7 timeout sticky", tmo, 1);
    summary();
  end
endmodule